// File: doc/BRIEF.md
# Queued Command Tag Tracker

This block keeps the host's record of which queued disk commands are in flight. It holds one bit per tag in an active-slot register. A queued issue request sets the bit for its tag, but only if the block accepts the request. A completion notice from the device carries a bitmask, and every tag named in that mask is retired in the same cycle. The block also offers the issuer the lowest free tag that lies below a programmable queue depth. A full flag shows when no tag is free.

Two rules protect the queue. First, an error reported by the device latches a freeze, and while frozen the block refuses further queued issue. Second, an attempt to issue a non-queued command while queued work is outstanding fails every outstanding command at once, reports them, and freezes the queue. A software clear lifts the freeze and empties the register. An active-low activity output is driven from the device busy flag together with the active-slot register.

Top module: `ncq_tag_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the active-slot register and the freeze latch clear and the `issue_ack`, `issue_nak` and `fail_valid` pulses go low. After release, `act_led_n` reads 1 while `dev_bsy` is 0.
- R2: A queued issue (`issue_valid`=1, `issue_queued`=1) is accepted when the queue is not frozen, the tag is below the effective depth, and the tag's bit is clear. On the next edge bit `issue_tag` of `active_slots` becomes 1 and `issue_ack` pulses for one cycle.
- R3: A queued issue whose tag bit is already set, or whose tag is at or above the effective depth, is refused. On the next edge `issue_nak` pulses and the register gains no bit.
- R4: When `sdb_valid` is 1, every bit set in `sdb_mask` is cleared from `active_slots` on the next edge. An issue in the same cycle is judged against the register as it stood before that clearing.
- R5: `free_tag` is the lowest tag below the effective depth whose bit is clear. `all_full` is 1 when no such tag exists, and `free_tag` is then 0. Both follow the register and `cfg_depth` without a clock delay.
- R6: An error (`sdb_valid` with `sdb_err`, or `d2h_valid` with `d2h_err`) sets `err_frozen` on the next edge. While it is set, every queued issue is refused. Completion masks still clear their bits while frozen.
- R7: A non-queued issue (`issue_queued`=0) while any slot is active is refused. On the next edge `fail_valid` pulses with `fail_mask` equal to the slots that were active, `active_slots` becomes 0, and `err_frozen` becomes 1.
- R8: A non-queued issue with no slot active is accepted when the queue is not frozen and refused when it is frozen. In both cases the register is left as it was.
- R9: `sw_clear` empties `active_slots` and clears `err_frozen` on the next edge. It takes precedence over every other input in that cycle. An issue request in the same cycle is refused.
- R10: `act_led_n` is 0 when `dev_bsy` is 1 or any bit of `active_slots` is set, and 1 otherwise. It has no clock delay from `dev_bsy`.
- R11: The effective depth is `cfg_depth`, limited to NUM_TAGS (32). Depth 0 makes every tag unavailable, so `all_full` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_depth | input | 6 | Programmed queue depth (tags below it usable) |
| issue_valid | input | 1 | Issue request present this cycle |
| issue_queued | input | 1 | 1 = queued command, 0 = non-queued command |
| issue_tag | input | 5 | Tag of a queued issue request |
| sdb_valid | input | 1 | Completion notice present this cycle |
| sdb_mask | input | 32 | Tags reported complete |
| sdb_err | input | 1 | Error flag carried by the completion notice |
| d2h_valid | input | 1 | Device register notice present this cycle |
| d2h_err | input | 1 | Error flag carried by the register notice |
| dev_bsy | input | 1 | Device busy flag |
| sw_clear | input | 1 | Software clear of freeze and active slots |
| active_slots | output | 32 | Active-slot register, one bit per tag |
| free_tag | output | 5 | Lowest free tag below the effective depth |
| all_full | output | 1 | No free tag below the effective depth |
| issue_ack | output | 1 | Pulse: previous cycle's issue accepted |
| issue_nak | output | 1 | Pulse: previous cycle's issue refused |
| fail_valid | output | 1 | Pulse: outstanding commands failed by mixing |
| fail_mask | output | 32 | Slots failed, valid with fail_valid |
| err_frozen | output | 1 | Queued issue frozen by an error |
| act_led_n | output | 1 | Activity indicator, active low |

## Verification
The registered results are `active_slots`, `err_frozen`, the accept and refuse pulses, and the failure report. Each of these is due at the first rising edge after the cycle that carries its stimulus. The free-tag result, the full flag and the activity output are combinational and follow that same edge, with no further delay. The bench changes inputs only on falling edges and samples one falling edge later, so exactly one rising edge lies between a stimulus and its check. At that sampling point `dev_bsy` and `cfg_depth` still hold the values the vector applied.

// File: rtl/ncq_pkg.sv
// Package: shared parameters and the issue verdict type for the tag tracker.
// Assumes at most 32 tags, as a queued command slot register is 32 bits.
package ncq_pkg;
    localparam int unsigned NCQ_MAX_TAGS = 32;

    // Outcome of judging one issue request against the current queue state.
    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_ACCEPT = 2'd1,
        VERDICT_REJECT = 2'd2,
        VERDICT_MIXFAIL = 2'd3
    } verdict_e;
endpackage

// File: rtl/ncq_depth_mask.sv
// Module: ncq_depth_mask
// Turns the programmed depth into a per-tag usable mask (tag < depth).
// Assumes depth values above NUM_TAGS simply enable every tag.
module ncq_depth_mask #(
    parameter int NUM_TAGS = 32,
    parameter int DEPTH_W  = $clog2(NUM_TAGS + 1)
) (
    input  logic [DEPTH_W-1:0]  depth,
    output logic [NUM_TAGS-1:0] usable
);
    // One comparator per tag; structure repeats so it is generated.
    for (genvar gi = 0; gi < NUM_TAGS; gi++) begin : g_cmp
        assign usable[gi] = (depth > DEPTH_W'(gi));
    end
endmodule

// File: rtl/ncq_lowest_free.sv
// Module: ncq_lowest_free
// Finds the lowest-numbered set bit in an availability vector.
// Assumes the caller already masked out busy and out-of-depth tags.
module ncq_lowest_free #(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic [NUM_TAGS-1:0] avail,
    output logic [TAG_W-1:0]    idx,
    output logic                none
);
    // Priority scan from the top down so the lowest index wins last.
    always_comb begin
        idx = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (avail[i]) idx = TAG_W'(i);
        end
        none = ~(|avail);
    end
endmodule

// File: rtl/ncq_issue_judge.sv
// Module: ncq_issue_judge
// Decides whether an issue request is accepted, refused, or fails the
// outstanding queue because a non-queued command was mixed in.
// Assumes active/frozen are the registered state before this cycle's update.
module ncq_issue_judge
    import ncq_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic                issue_valid,
    input  logic                issue_queued,
    input  logic [TAG_W-1:0]    issue_tag,
    input  logic [NUM_TAGS-1:0] active,
    input  logic [NUM_TAGS-1:0] usable,
    input  logic                frozen,
    input  logic                clear,
    output verdict_e            verdict
);
    logic tag_open;
    logic any_active;

    // Tag is open when within depth and its slot is idle.
    always_comb begin
        tag_open   = usable[issue_tag] & ~active[issue_tag];
        any_active = |active;
    end

    // Verdict priority: clear, then queued rules, then non-queued rules.
    always_comb begin
        if (!issue_valid) begin
            verdict = VERDICT_NONE;
        end else if (clear) begin
            verdict = VERDICT_REJECT;
        end else if (issue_queued) begin
            verdict = (!frozen && tag_open) ? VERDICT_ACCEPT : VERDICT_REJECT;
        end else if (any_active) begin
            verdict = VERDICT_MIXFAIL;
        end else begin
            verdict = frozen ? VERDICT_REJECT : VERDICT_ACCEPT;
        end
    end
endmodule

// File: rtl/ncq_tag_tracker.sv
// Module: ncq_tag_tracker (top)
// Host-side record of in-flight queued commands: sets slots on accepted
// queued issue, retires slots from completion masks, offers the lowest free
// tag, freezes on device errors or mixed command kinds, drives activity.
// Assumes one issue request and one notice of each kind per cycle at most.
module ncq_tag_tracker
    import ncq_pkg::*;
#(
    parameter int NUM_TAGS = NCQ_MAX_TAGS,
    localparam int TAG_W   = $clog2(NUM_TAGS),
    localparam int DEPTH_W = $clog2(NUM_TAGS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEPTH_W-1:0]  cfg_depth,
    input  logic                issue_valid,
    input  logic                issue_queued,
    input  logic [TAG_W-1:0]    issue_tag,
    input  logic                sdb_valid,
    input  logic [NUM_TAGS-1:0] sdb_mask,
    input  logic                sdb_err,
    input  logic                d2h_valid,
    input  logic                d2h_err,
    input  logic                dev_bsy,
    input  logic                sw_clear,
    output logic [NUM_TAGS-1:0] active_slots,
    output logic [TAG_W-1:0]    free_tag,
    output logic                all_full,
    output logic                issue_ack,
    output logic                issue_nak,
    output logic                fail_valid,
    output logic [NUM_TAGS-1:0] fail_mask,
    output logic                err_frozen,
    output logic                act_led_n
);
    logic [NUM_TAGS-1:0] usable;
    logic [NUM_TAGS-1:0] avail;
    logic [NUM_TAGS-1:0] set_vec;
    logic [NUM_TAGS-1:0] retire_vec;
    logic [NUM_TAGS-1:0] active_nxt;
    logic                err_seen;
    verdict_e            verdict;

    ncq_depth_mask #(.NUM_TAGS(NUM_TAGS), .DEPTH_W(DEPTH_W)) u_depth (
        .depth  (cfg_depth),
        .usable (usable)
    );

    // Free tags are those within depth whose slot is idle.
    always_comb avail = usable & ~active_slots;

    ncq_lowest_free #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_free (
        .avail (avail),
        .idx   (free_tag),
        .none  (all_full)
    );

    ncq_issue_judge #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_judge (
        .issue_valid  (issue_valid),
        .issue_queued (issue_queued),
        .issue_tag    (issue_tag),
        .active       (active_slots),
        .usable       (usable),
        .frozen       (err_frozen),
        .clear        (sw_clear),
        .verdict      (verdict)
    );

    // Build the set and retire vectors and the next slot state.
    always_comb begin
        set_vec    = '0;
        retire_vec = sdb_valid ? sdb_mask : '0;
        if (verdict == VERDICT_ACCEPT && issue_queued)
            set_vec[issue_tag] = 1'b1;
        if (verdict == VERDICT_MIXFAIL)
            active_nxt = '0;
        else
            active_nxt = (active_slots & ~retire_vec) | set_vec;
        err_seen = (sdb_valid & sdb_err) | (d2h_valid & d2h_err);
    end

    // Slot register and freeze latch; clear overrides all other events.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear) begin
            active_slots <= '0;
            err_frozen   <= 1'b0;
        end else begin
            active_slots <= active_nxt;
            err_frozen   <= err_frozen | err_seen | (verdict == VERDICT_MIXFAIL);
        end
    end

    // One-cycle result pulses and the failure report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_ack  <= 1'b0;
            issue_nak  <= 1'b0;
            fail_valid <= 1'b0;
            fail_mask  <= '0;
        end else begin
            issue_ack  <= (verdict == VERDICT_ACCEPT);
            issue_nak  <= (verdict == VERDICT_REJECT) || (verdict == VERDICT_MIXFAIL);
            fail_valid <= (verdict == VERDICT_MIXFAIL);
            fail_mask  <= (verdict == VERDICT_MIXFAIL) ? active_slots : '0;
        end
    end

    // Activity indicator, active low, from busy flag or any active slot.
    always_comb act_led_n = ~(dev_bsy | (|active_slots));
endmodule

// File: rtl/ncq_tag_tracker_chk.sv
// Module: ncq_tag_tracker_chk
// Property checker bound to the tracker top; observes ports only.
module ncq_tag_tracker_chk #(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = $clog2(NUM_TAGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                issue_valid,
    input logic                issue_queued,
    input logic [TAG_W-1:0]    issue_tag,
    input logic                sdb_valid,
    input logic [NUM_TAGS-1:0] sdb_mask,
    input logic                sw_clear,
    input logic [NUM_TAGS-1:0] active_slots,
    input logic                issue_ack,
    input logic                issue_nak,
    input logic                fail_valid,
    input logic                err_frozen,
    input logic                act_led_n
);
    // R2
    ack_sets_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ack && $past(issue_valid && issue_queued)) |-> active_slots[$past(issue_tag)]);

    // R3
    ack_nak_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_ack && issue_nak));

    // R4
    retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sdb_valid) && !$past(issue_valid)) |-> ((active_slots & $past(sdb_mask)) == '0));

    // R7
    mixfail_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_valid |-> (active_slots == '0 && err_frozen && issue_nak));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_clear) |-> (active_slots == '0 && !err_frozen && !issue_ack));

    // R10
    led_on_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_slots != '0) |-> !act_led_n);
endmodule

bind ncq_tag_tracker ncq_tag_tracker_chk #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .issue_queued (issue_queued),
    .issue_tag    (issue_tag),
    .sdb_valid    (sdb_valid),
    .sdb_mask     (sdb_mask),
    .sw_clear     (sw_clear),
    .active_slots (active_slots),
    .issue_ack    (issue_ack),
    .issue_nak    (issue_nak),
    .fail_valid   (fail_valid),
    .err_frozen   (err_frozen),
    .act_led_n    (act_led_n)
);

// File: tb/ncq_tag_tracker_test.sv
module ncq_tag_tracker_test;
    localparam int PERIOD = 10;
    localparam int NV     = 21;

    typedef struct packed {
        logic        iv;
        logic        q;
        logic [4:0]  tag;
        logic        sv;
        logic [31:0] smask;
        logic        serr;
        logic        rv;
        logic        rerr;
        logic        bsy;
        logic        clr;
        logic [5:0]  depth;
        logic [31:0] e_act;
        logic        e_ack;
        logic        e_nak;
        logic        e_fail;
        logic [31:0] e_fmask;
        logic        e_frz;
        logic [4:0]  e_free;
        logic        e_full;
        logic        e_led;
    } vec_t;

    // iv q tag  sv smask serr rv rerr bsy clr depth | act ack nak fail fmask frz free full led
    localparam vec_t VEC [NV] = '{
        '{0,0,5'd0, 0,32'h0,0, 0,0, 1,0, 6'd32, 32'h0,        0,0,0,32'h0,        0,5'd0,0,0}, // R10 busy only
        '{1,1,5'd0, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'h1,        1,0,0,32'h0,        0,5'd1,0,0}, // R2
        '{1,1,5'd3, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'h9,        1,0,0,32'h0,        0,5'd1,0,0}, // R2 R5
        '{1,1,5'd3, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'h9,        0,1,0,32'h0,        0,5'd1,0,0}, // R3 busy tag
        '{1,1,5'd1, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'hB,        1,0,0,32'h0,        0,5'd2,0,0}, // R2 R5
        '{0,0,5'd0, 1,32'h9,0, 0,0, 0,0, 6'd32, 32'h2,        0,0,0,32'h0,        0,5'd0,0,0}, // R4 multi retire
        '{1,1,5'd4, 0,32'h0,0, 0,0, 0,0, 6'd4,  32'h2,        0,1,0,32'h0,        0,5'd0,0,0}, // R3 R11 beyond depth
        '{1,1,5'd0, 0,32'h0,0, 0,0, 0,0, 6'd2,  32'h3,        1,0,0,32'h0,        0,5'd0,1,0}, // R5 R11 full at depth
        '{1,1,5'd1, 1,32'h1,0, 0,0, 0,0, 6'd2,  32'h2,        0,1,0,32'h0,        0,5'd0,0,0}, // R4 pre-clear judge
        '{0,0,5'd0, 1,32'h2,0, 0,0, 0,0, 6'd32, 32'h0,        0,0,0,32'h0,        0,5'd0,0,1}, // R4 R10 led off
        '{1,1,5'd31,0,32'h0,0, 0,0, 0,0, 6'd32, 32'h80000000, 1,0,0,32'h0,        0,5'd0,0,0}, // R2 top tag
        '{1,0,5'd0, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'h0,        0,1,1,32'h80000000, 1,5'd0,0,1}, // R7 mix
        '{1,1,5'd2, 0,32'h0,0, 0,0, 1,0, 6'd32, 32'h0,        0,1,0,32'h0,        1,5'd0,0,0}, // R6 frozen refuse
        '{0,0,5'd0, 0,32'h0,0, 0,0, 0,1, 6'd32, 32'h0,        0,0,0,32'h0,        0,5'd0,0,1}, // R9 clear
        '{1,0,5'd0, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'h0,        1,0,0,32'h0,        0,5'd0,0,1}, // R8 non-queued ok
        '{1,1,5'd5, 0,32'h0,0, 0,0, 0,0, 6'd32, 32'h20,       1,0,0,32'h0,        0,5'd0,0,0}, // R2
        '{0,0,5'd0, 0,32'h0,0, 1,1, 0,0, 6'd32, 32'h20,       0,0,0,32'h0,        1,5'd0,0,0}, // R6 reg error
        '{0,0,5'd0, 1,32'h20,1,0,0, 0,0, 6'd32, 32'h0,        0,0,0,32'h0,        1,5'd0,0,1}, // R6 retire while frozen
        '{1,1,5'd0, 0,32'h0,0, 0,0, 0,1, 6'd32, 32'h0,        0,1,0,32'h0,        0,5'd0,0,1}, // R9 issue refused
        '{1,1,5'd7, 1,32'h0,1, 0,0, 0,0, 6'd32, 32'h80,       1,0,0,32'h0,        1,5'd0,0,0}, // R6 R2 err same cycle
        '{0,0,5'd0, 0,32'h0,0, 0,0, 0,1, 6'd32, 32'h0,        0,0,0,32'h0,        0,5'd0,0,1}  // R9 empties slots
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_depth = 6'd32;
    logic        issue_valid = 1'b0, issue_queued = 1'b0;
    logic [4:0]  issue_tag = '0;
    logic        sdb_valid = 1'b0, sdb_err = 1'b0;
    logic [31:0] sdb_mask = '0;
    logic        d2h_valid = 1'b0, d2h_err = 1'b0;
    logic        dev_bsy = 1'b0, sw_clear = 1'b0;
    logic [31:0] active_slots, fail_mask;
    logic [4:0]  free_tag;
    logic        all_full, issue_ack, issue_nak, fail_valid, err_frozen, act_led_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    ncq_tag_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .issue_valid(issue_valid), .issue_queued(issue_queued), .issue_tag(issue_tag),
        .sdb_valid(sdb_valid), .sdb_mask(sdb_mask), .sdb_err(sdb_err),
        .d2h_valid(d2h_valid), .d2h_err(d2h_err), .dev_bsy(dev_bsy), .sw_clear(sw_clear),
        .active_slots(active_slots), .free_tag(free_tag), .all_full(all_full),
        .issue_ack(issue_ack), .issue_nak(issue_nak), .fail_valid(fail_valid),
        .fail_mask(fail_mask), .err_frozen(err_frozen), .act_led_n(act_led_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        issue_valid = 0; issue_queued = 0; issue_tag = '0;
        sdb_valid = 0; sdb_mask = '0; sdb_err = 0;
        d2h_valid = 0; d2h_err = 0; dev_bsy = 0; sw_clear = 0;
    endtask

    // Drive on a falling edge; result sampled at the next falling edge.
    task automatic queued_issue(input logic [4:0] t);
        idle_inputs();
        issue_valid = 1; issue_queued = 1; issue_tag = t;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 active", active_slots, 32'h0);
        chk("R1 frozen", {31'b0, err_frozen}, 32'h0);
        chk("R1 pulses", {29'b0, issue_ack, issue_nak, fail_valid}, 32'h0);
        chk("R1 led", {31'b0, act_led_n}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            issue_valid = VEC[i].iv; issue_queued = VEC[i].q; issue_tag = VEC[i].tag;
            sdb_valid = VEC[i].sv; sdb_mask = VEC[i].smask; sdb_err = VEC[i].serr;
            d2h_valid = VEC[i].rv; d2h_err = VEC[i].rerr;
            dev_bsy = VEC[i].bsy; sw_clear = VEC[i].clr; cfg_depth = VEC[i].depth;
            @(negedge clk);
            chk($sformatf("R2/R4 active v%0d", i), active_slots, VEC[i].e_act);
            chk($sformatf("R2 ack v%0d", i), {31'b0, issue_ack}, {31'b0, VEC[i].e_ack});
            chk($sformatf("R3 nak v%0d", i), {31'b0, issue_nak}, {31'b0, VEC[i].e_nak});
            chk($sformatf("R7 fail v%0d", i), {31'b0, fail_valid}, {31'b0, VEC[i].e_fail});
            if (VEC[i].e_fail)
                chk($sformatf("R7 fail_mask v%0d", i), fail_mask, VEC[i].e_fmask);
            chk($sformatf("R6 frozen v%0d", i), {31'b0, err_frozen}, {31'b0, VEC[i].e_frz});
            chk($sformatf("R5 free v%0d", i), {27'b0, free_tag}, {27'b0, VEC[i].e_free});
            chk($sformatf("R5 full v%0d", i), {31'b0, all_full}, {31'b0, VEC[i].e_full});
            chk($sformatf("R10 led v%0d", i), {31'b0, act_led_n}, {31'b0, VEC[i].e_led});
        end

        // R5: fill every slot, then check full and refuse one more
        cfg_depth = 6'd32;
        for (int t = 0; t < 32; t++) queued_issue(5'(t));
        chk("R5 all set", active_slots, 32'hFFFFFFFF);
        chk("R5 full flag", {31'b0, all_full}, 32'h1);
        queued_issue(5'd0);
        chk("R3 refuse when full", {31'b0, issue_nak}, 32'h1);

        // R8: frozen and empty queue refuses a non-queued command
        idle_inputs(); sdb_valid = 1; sdb_mask = 32'hFFFFFFFF; sdb_err = 1;
        @(negedge clk);
        idle_inputs(); issue_valid = 1; issue_queued = 0;
        @(negedge clk);
        chk("R8 frozen non-queued nak", {30'b0, issue_ack, issue_nak}, 32'h1);
        chk("R8 slots untouched", active_slots, 32'h0);

        // R11: depth 0 leaves no tag; depth above 32 acts as 32
        idle_inputs(); sw_clear = 1;
        @(negedge clk);
        idle_inputs(); cfg_depth = 6'd0;
        #1;
        chk("R11 depth zero full", {31'b0, all_full}, 32'h1);
        cfg_depth = 6'd40;
        queued_issue(5'd31);
        chk("R11 large depth accepts top tag", active_slots, 32'h80000000);
        chk("R11 large depth free", {26'b0, all_full, free_tag}, 32'h0);

        // R1: reset in the middle of activity
        idle_inputs(); rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 mid reset active", active_slots, 32'h0);
        chk("R1 mid reset led", {31'b0, act_led_n}, 32'h1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule